// File: doc/BRIEF.md
# Inter-core doorbell message router

This block carries doorbell messages between N processor threads. Each thread can present one command per cycle. A command is a send, a clear or a synchronize, and it comes with a 64-bit operand. A send with the correct message type sets a hypervisor-doorbell pending bit on each thread whose 20-bit processor ID matches the tag in the operand. That raises the thread's interrupt request. A clear drops the pending bit of the thread that issued it. Only threads running in hypervisor state may issue commands. A command from any other thread is discarded, and a privilege-error pulse reports it.

Each thread also has a small priority selector. It holds three pending sources: the ordinary directed doorbell, the hypervisor doorbell and the performance monitor. When the thread asks to take an interrupt, the selector grants the most urgent pending source and acknowledges it. The granted bit is retired in the same step. A hypervisor-doorbell grant is marked as hypervisor-class, so the vectoring logic uses the hypervisor save/restore register pair. All outputs are registered.

Top module: `doorbell_router`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every output is zero.
- R2: A hypervisor-state send (`cmd_kind` = 2'b01) whose operand bits 31:27 equal 5 sets `hdbell_pend` and `irq_req` one cycle later on every thread whose `proc_id` equals operand bits 19:0.
- R3: A send or clear whose operand bits 31:27 hold any value other than 5 changes no pending bit on any thread.
- R4: A hypervisor-state clear (`cmd_kind` = 2'b10) of type 5 resets the issuing thread's `hdbell_pend` one cycle later and leaves every other thread unchanged.
- R5: When operand bit 26 is set, a send reaches every thread whose processor ID equals the tag once the low log2(THREADS_PER_CORE) bits are ignored.
- R6: If a send and a clear, or a send and a take, hit the same thread's hypervisor-doorbell bit in the same cycle, the bit stays set.
- R7: A command with a non-zero kind from a thread whose `hv_state` is low changes no state and pulses that thread's `priv_err` for one cycle, one cycle later.
- R8: A synchronize command (`cmd_kind` = 2'b11) from a hypervisor-state thread changes no state and raises no error. Kind 2'b00 is no command.
- R9: On `take`, the next cycle shows a one-hot `grant` for that thread (bit 0 directed doorbell, bit 1 hypervisor doorbell, bit 2 performance monitor), with the directed doorbell first, then the hypervisor doorbell, then the performance monitor. The granted pending bit is cleared.
- R10: `grant_hv` is high exactly when the hypervisor doorbell is granted.
- R11: `ack` pulses for one cycle per taken interrupt. A take with nothing pending gives no grant and no ack.
- R12: `dbell_set` and `pmu_set` pulses set their pending sources, and `irq_req` is high the next cycle whenever any source of that thread is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | N | Command present, one bit per thread |
| cmd_kind | input | 2*N | Command kind per thread: 01 send, 10 clear, 11 sync |
| cmd_opnd | input | 64*N | Command operand per thread |
| hv_state | input | N | Thread runs in hypervisor state |
| proc_id | input | 20*N | Processor ID of each thread |
| dbell_set | input | N | Set the directed-doorbell pending bit |
| pmu_set | input | N | Set the performance-monitor pending bit |
| take | input | N | Thread takes its next pending interrupt |
| hdbell_pend | output | N | Hypervisor-doorbell pending bits |
| irq_req | output | N | Interrupt request per thread |
| grant | output | 3*N | One-hot grant per thread |
| grant_hv | output | N | Grant is hypervisor-class |
| ack | output | N | One-cycle acknowledge per taken interrupt |
| priv_err | output | N | Command dropped for lack of privilege |

## Verification
Every result of this block appears one clock edge after the input that causes it. Pending bits, interrupt requests, grants, acknowledges and privilege errors all come from a single register stage. The bench drives inputs on the falling edge and keeps a behavioural model that moves forward on each rising edge. On the next falling edge it compares all six outputs with that model, so every result is checked in exactly the cycle it is due. The directed checks are sampled on the falling edge that follows the command edge. They confirm the one-cycle pulses (ack, priv_err) and the outputs that must not change in that same window.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int OPND_W    = 64;
  localparam int TAG_W     = 20;
  localparam int TYPE_LO   = 27;
  localparam int TYPE_W    = 5;
  localparam int BCAST_BIT = 26;
  localparam logic [TYPE_W-1:0] HV_DBELL_TYPE = 5'd5;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_SEND  = 2'b01,
    CMD_CLEAR = 2'b10,
    CMD_SYNC  = 2'b11
  } cmd_kind_e;

  typedef struct packed {
    logic             send;
    logic             clear;
    logic             bcast;
    logic [TAG_W-1:0] tag;
    logic             priv_bad;
  } cmd_dec_t;
endpackage

// File: rtl/dbell_cmd_decode.sv
module dbell_cmd_decode
  import dbell_pkg::*;
(
  input  logic              vld,
  input  logic [1:0]        kind,
  input  logic [OPND_W-1:0] opnd,
  input  logic              hv,
  output cmd_dec_t          dec
);
  logic type_ok;
  logic unused_opnd;

  assign type_ok     = (opnd[TYPE_LO +: TYPE_W] == HV_DBELL_TYPE);
  assign unused_opnd = ^{opnd[OPND_W-1:TYPE_LO+TYPE_W], opnd[BCAST_BIT-1:TAG_W]};

  always_comb begin
    dec          = '0;
    dec.send     = vld && hv && (kind == CMD_SEND)  && type_ok;
    dec.clear    = vld && hv && (kind == CMD_CLEAR) && type_ok;
    dec.bcast    = opnd[BCAST_BIT];
    dec.tag      = opnd[TAG_W-1:0];
    dec.priv_bad = vld && !hv && (kind != CMD_NONE);
  end
endmodule

// File: rtl/dbell_target_match.sv
module dbell_target_match
  import dbell_pkg::*;
#(
  parameter int N   = 4,
  parameter int TPC = 2
) (
  input  logic               send,
  input  logic               bcast,
  input  logic [TAG_W-1:0]   tag,
  input  logic [N*TAG_W-1:0] proc_id,
  output logic [N-1:0]       hit
);
  localparam int LOW = (TPC > 1) ? $clog2(TPC) : 0;
  localparam logic [TAG_W-1:0] LOW_MASK = TAG_W'((1 << LOW) - 1);

  logic [TAG_W-1:0] care;
  assign care = bcast ? ~LOW_MASK : '1;

  for (genvar t = 0; t < N; t++) begin : g_cmp
    assign hit[t] = send && (((proc_id[t*TAG_W +: TAG_W] ^ tag) & care) == '0);
  end
endmodule

// File: rtl/dbell_thread_sel.sv
module dbell_thread_sel (
  input  logic       clk,
  input  logic       rst,
  input  logic       hd_set,
  input  logic       hd_clr,
  input  logic       db_set,
  input  logic       pm_set,
  input  logic       take,
  output logic       hd_pend,
  output logic       irq,
  output logic [2:0] grant,
  output logic       grant_hv,
  output logic       ack
);
  logic       db_q, hd_q, pm_q;
  logic       db_n, hd_n, pm_n;
  logic [2:0] pick, taken;
  logic       any;

  assign any = db_q | hd_q | pm_q;

  always_comb begin
    if (db_q)      pick = 3'b001;
    else if (hd_q) pick = 3'b010;
    else if (pm_q) pick = 3'b100;
    else           pick = 3'b000;
    taken = take ? pick : 3'b000;
    db_n  = (db_q & ~taken[0]) | db_set;
    hd_n  = (hd_q & ~taken[1] & ~hd_clr) | hd_set;
    pm_n  = (pm_q & ~taken[2]) | pm_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      db_q     <= 1'b0;
      hd_q     <= 1'b0;
      pm_q     <= 1'b0;
      irq      <= 1'b0;
      grant    <= 3'b000;
      grant_hv <= 1'b0;
      ack      <= 1'b0;
    end else begin
      db_q     <= db_n;
      hd_q     <= hd_n;
      pm_q     <= pm_n;
      irq      <= db_n | hd_n | pm_n;
      grant    <= taken;
      grant_hv <= taken[1];
      ack      <= take & any;
    end
  end

  assign hd_pend = hd_q;
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
  import dbell_pkg::*;
#(
  parameter int N   = 4,
  parameter int TPC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        cmd_vld,
  input  logic [2*N-1:0]      cmd_kind,
  input  logic [N*OPND_W-1:0] cmd_opnd,
  input  logic [N-1:0]        hv_state,
  input  logic [N*TAG_W-1:0]  proc_id,
  input  logic [N-1:0]        dbell_set,
  input  logic [N-1:0]        pmu_set,
  input  logic [N-1:0]        take,
  output logic [N-1:0]        hdbell_pend,
  output logic [N-1:0]        irq_req,
  output logic [3*N-1:0]      grant,
  output logic [N-1:0]        grant_hv,
  output logic [N-1:0]        ack,
  output logic [N-1:0]        priv_err
);
  cmd_dec_t     dec [N];
  logic [N-1:0] hit [N];
  logic [N-1:0] hd_set, hd_clr, bad;

  for (genvar i = 0; i < N; i++) begin : g_issuer
    dbell_cmd_decode u_dec (
      .vld  (cmd_vld[i]),
      .kind (cmd_kind[2*i +: 2]),
      .opnd (cmd_opnd[i*OPND_W +: OPND_W]),
      .hv   (hv_state[i]),
      .dec  (dec[i])
    );
    dbell_target_match #(.N(N), .TPC(TPC)) u_match (
      .send    (dec[i].send),
      .bcast   (dec[i].bcast),
      .tag     (dec[i].tag),
      .proc_id (proc_id),
      .hit     (hit[i])
    );
    assign hd_clr[i] = dec[i].clear;
    assign bad[i]    = dec[i].priv_bad;
  end

  always_comb begin
    hd_set = '0;
    for (int i = 0; i < N; i++) hd_set = hd_set | hit[i];
  end

  for (genvar t = 0; t < N; t++) begin : g_thread
    dbell_thread_sel u_sel (
      .clk      (clk),
      .rst      (rst),
      .hd_set   (hd_set[t]),
      .hd_clr   (hd_clr[t]),
      .db_set   (dbell_set[t]),
      .pm_set   (pmu_set[t]),
      .take     (take[t]),
      .hd_pend  (hdbell_pend[t]),
      .irq      (irq_req[t]),
      .grant    (grant[3*t +: 3]),
      .grant_hv (grant_hv[t]),
      .ack      (ack[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) priv_err <= '0;
    else     priv_err <= bad;
  end
endmodule

// File: rtl/doorbell_router_chk.sv
module doorbell_router_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   cmd_vld,
  input logic [N-1:0]   hv_state,
  input logic [N-1:0]   take,
  input logic [N-1:0]   hdbell_pend,
  input logic [N-1:0]   irq_req,
  input logic [3*N-1:0] grant,
  input logic [N-1:0]   grant_hv,
  input logic [N-1:0]   ack
);
  for (genvar g = 0; g < N; g++) begin : g_chk
    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant[3*g +: 3]));
    p_ack_after_take_r11: assert property (@(posedge clk) disable iff (rst)
      ack[g] |-> $past(take[g]));
    p_grant_has_ack_r11: assert property (@(posedge clk) disable iff (rst)
      (grant[3*g +: 3] != 3'b000) |-> ack[g]);
    p_hv_from_pend_r10: assert property (@(posedge clk) disable iff (rst)
      grant_hv[g] |-> $past(hdbell_pend[g]));
    p_hv_marks_hd_r10: assert property (@(posedge clk) disable iff (rst)
      grant[3*g+1] |-> grant_hv[g]);
    p_pend_raises_irq_r2: assert property (@(posedge clk) disable iff (rst)
      hdbell_pend[g] |-> irq_req[g]);
    p_nonhv_no_set_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd_vld == (1 << g) && !hv_state[g] && !hdbell_pend[g] && !take[g]) |=> $stable(hdbell_pend));
  end
endmodule

bind doorbell_router doorbell_router_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_vld     (cmd_vld),
  .hv_state    (hv_state),
  .take        (take),
  .hdbell_pend (hdbell_pend),
  .irq_req     (irq_req),
  .grant       (grant),
  .grant_hv    (grant_hv),
  .ack         (ack)
);

// File: tb/sim_doorbell_router.sv
module sim_doorbell_router;
  localparam int N = 4;
  localparam int TPC = 2;
  localparam int LOW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    cmd_vld = '0;
  logic [2*N-1:0]  cmd_kind = '0;
  logic [N*64-1:0] cmd_opnd = '0;
  logic [N-1:0]    hv_state = '1;
  logic [N*20-1:0] proc_id;
  logic [N-1:0]    dbell_set = '0, pmu_set = '0, take = '0;
  logic [N-1:0]    hdbell_pend, irq_req, grant_hv, ack, priv_err;
  logic [3*N-1:0]  grant;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  doorbell_router #(.N(N), .TPC(TPC)) u0 (.*);

  // reference model
  logic [N-1:0] m_db = '0, m_hd = '0, m_pm = '0, m_irq = '0, m_hv = '0, m_ack = '0, m_priv = '0;
  logic [3*N-1:0] m_grant = '0;
  logic [N-1:0] hs, hc;
  logic [2:0] g;
  logic [63:0] op;
  logic [19:0] tg, id;

  always @(posedge clk) begin
    if (rst) begin
      m_db = '0; m_hd = '0; m_pm = '0; m_irq = '0; m_hv = '0;
      m_ack = '0; m_priv = '0; m_grant = '0;
    end else begin
      hs = '0; hc = '0;
      for (int i = 0; i < N; i++) begin
        op = cmd_opnd[i*64 +: 64];
        m_priv[i] = cmd_vld[i] && !hv_state[i] && (cmd_kind[2*i +: 2] != 2'b00);
        if (cmd_vld[i] && hv_state[i] && op[31:27] == 5'd5) begin
          if (cmd_kind[2*i +: 2] == 2'b10) hc[i] = 1'b1;
          if (cmd_kind[2*i +: 2] == 2'b01) begin
            tg = op[19:0];
            for (int t = 0; t < N; t++) begin
              id = proc_id[t*20 +: 20];
              if (op[26] ? ((id >> LOW) == (tg >> LOW)) : (id == tg)) hs[t] = 1'b1;
            end
          end
        end
      end
      for (int t = 0; t < N; t++) begin
        g = 3'b000;
        if (take[t]) begin
          if (m_db[t]) g = 3'b001;
          else if (m_hd[t]) g = 3'b010;
          else if (m_pm[t]) g = 3'b100;
        end
        m_grant[3*t +: 3] = g;
        m_hv[t]  = g[1];
        m_ack[t] = (g != 3'b000);
        m_db[t]  = (m_db[t] && !g[0]) || dbell_set[t];
        m_hd[t]  = (m_hd[t] && !g[1] && !hc[t]) || hs[t];
        m_pm[t]  = (m_pm[t] && !g[2]) || pmu_set[t];
        m_irq[t] = m_db[t] || m_hd[t] || m_pm[t];
      end
    end
    started = 1;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 model hdbell_pend", 64'(hdbell_pend), 64'(m_hd));
      chk("R12 model irq_req", 64'(irq_req), 64'(m_irq));
      chk("R9 model grant", 64'(grant), 64'(m_grant));
      chk("R10 model grant_hv", 64'(grant_hv), 64'(m_hv));
      chk("R11 model ack", 64'(ack), 64'(m_ack));
      chk("R7 model priv_err", 64'(priv_err), 64'(m_priv));
    end
  end

  function automatic logic [63:0] mkop(logic [4:0] ty, logic bc, logic [19:0] tag);
    return {32'h0, ty, bc, 6'h0, tag};
  endfunction

  task automatic put(int th, logic [1:0] k, logic [63:0] o);
    cmd_vld[th] = 1'b1;
    cmd_kind[2*th +: 2] = k;
    cmd_opnd[th*64 +: 64] = o;
  endtask

  task automatic fire();
    @(negedge clk);
    cmd_vld = '0; cmd_kind = '0; cmd_opnd = '0;
    dbell_set = '0; pmu_set = '0; take = '0; hv_state = '1;
  endtask

  task automatic one(int th, logic [1:0] k, logic [63:0] o);
    @(negedge clk);
    put(th, k, o);
    fire();
  endtask

  task automatic take1(int th);
    @(negedge clk);
    take[th] = 1'b1;
    fire();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    proc_id = {20'h00010, 20'h00020, 20'h00011, 20'h00010};
    repeat (3) @(negedge clk);
    chk("R1 reset pend", 64'(hdbell_pend), 0);
    chk("R1 reset grant", 64'(grant), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset irq", 64'(irq_req), 0);

    one(2, 2'b01, mkop(5'd5, 1'b0, 20'h00010));
    chk("R2 send sets matching", 64'(hdbell_pend), 64'b1001);
    chk("R2 send raises irq", 64'(irq_req), 64'b1001);

    one(2, 2'b01, mkop(5'd4, 1'b0, 20'h00020));
    chk("R3 wrong-type send", 64'(hdbell_pend), 64'b1001);
    one(0, 2'b10, mkop(5'd3, 1'b0, 20'h0));
    chk("R3 wrong-type clear", 64'(hdbell_pend), 64'b1001);

    one(0, 2'b10, mkop(5'd5, 1'b0, 20'h0));
    chk("R4 clear own only", 64'(hdbell_pend), 64'b1000);

    one(2, 2'b01, mkop(5'd5, 1'b1, 20'h00011));
    chk("R5 broadcast", 64'(hdbell_pend), 64'b1011);

    one(1, 2'b11, mkop(5'd5, 1'b0, 20'h00020));
    chk("R8 sync no change", 64'(hdbell_pend), 64'b1011);
    chk("R8 sync no error", 64'(priv_err), 0);

    @(negedge clk);
    hv_state[1] = 1'b0;
    put(1, 2'b01, mkop(5'd5, 1'b0, 20'h00020));
    fire();
    chk("R7 non-hv dropped", 64'(hdbell_pend), 64'b1011);
    chk("R7 priv_err pulse", 64'(priv_err), 64'b0010);
    @(negedge clk);
    chk("R7 priv_err one cycle", 64'(priv_err), 0);

    @(negedge clk);
    put(0, 2'b10, mkop(5'd5, 1'b0, 20'h0));
    put(2, 2'b01, mkop(5'd5, 1'b0, 20'h00010));
    fire();
    chk("R6 send beats clear", 64'(hdbell_pend), 64'b1011);

    @(negedge clk);
    dbell_set[1] = 1'b1; pmu_set[1] = 1'b1;
    fire();
    chk("R12 sources raise irq", 64'(irq_req[1]), 1);
    take1(1);
    chk("R9 doorbell first", 64'(grant[5:3]), 64'b001);
    chk("R11 ack pulse", 64'(ack), 64'b0010);
    take1(1);
    chk("R9 hyp doorbell second", 64'(grant[5:3]), 64'b010);
    chk("R10 grant_hv", 64'(grant_hv), 64'b0010);
    chk("R9 taken bit cleared", 64'(hdbell_pend), 64'b1001);
    take1(1);
    chk("R9 pmu last", 64'(grant[5:3]), 64'b100);
    chk("R10 pmu not hv", 64'(grant_hv), 0);
    take1(1);
    chk("R11 empty take no grant", 64'(grant[5:3]), 0);
    chk("R11 empty take no ack", 64'(ack), 0);
    chk("R12 irq drops", 64'(irq_req[1]), 0);

    @(negedge clk);
    take[3] = 1'b1;
    put(2, 2'b01, mkop(5'd5, 1'b0, 20'h00010));
    fire();
    chk("R6 send beats take", 64'(hdbell_pend[3]), 1);
    chk("R10 take hv grant", 64'(grant_hv), 64'b1000);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule